// File: doc/BRIEF.md
# Execution trace record parser

This block turns a byte stream of instruction-trace records into individual operand descriptions. Bytes arrive one per valid/ready handshake, most-significant byte first within each multi-byte field. A record holds an optional 32-bit speculation word, one opcode byte, and three bytes that pack six 4-bit operand descriptors. One 32-bit operand word follows for each used descriptor, so record length varies with the descriptor contents.

Each operand is offered on an output handshake with its size in bytes, whether it was read or written, its position in the record, and whether it names a register or a memory address. A non-positive operand word names a register whose number is the word's negation. A positive word is a memory address. The speculation word and opcode of the current record are held on outputs until the record ends. The end is marked by a one-cycle done pulse. A static parameter removes the speculation word for traces that lack it. Malformed descriptor bytes raise a sticky error and the parser drops the record.

Top module: `trace_rec_parser`

## Requirements
- R1: After reset, `in_ready` is 1 and `op_valid`, `rec_done` and `fmt_err` are 0.
- R2: With the speculation word enabled, the first four bytes of a record form `rec_spec_flag`, most-significant byte first. The value is passed unchanged, including 0 and 0x80000000, and is visible while `rec_done` is high.
- R3: The next byte is the opcode, shown on `rec_opcode` during `rec_done`. It is followed by three descriptor bytes. Descriptor 0 is bits [7:4] of the first descriptor byte and descriptor 5 is bits [3:0] of the third. In each descriptor, bits [3:2] are the size code and bits [1:0] are the access code.
- R4: Size code 0, 1, 2, 3 gives `op_size` 1, 2, 4, 8. Access code 1 (read) gives `op_is_write` 0 and access code 2 (write) gives `op_is_write` 1.
- R5: One 4-byte operand word follows for each nonzero descriptor. Operands are emitted in descriptor order with `op_index` 0, 1, 2, and so on, one per output handshake, with none missing and none extra.
- R6: An operand word that is zero or negative as a signed 32-bit value gives `op_is_mem` 0 and `op_value` equal to its negation, so zero means register 0. A positive word gives `op_is_mem` 1 and `op_value` equal to the word.
- R7: `rec_done` is high for exactly one cycle. That cycle is the one after the handshake that accepts the record's last operand, or the one after the last descriptor byte is accepted when no descriptor is used. It is never high at any other time.
- R8: While `op_valid` is high and `op_ready` is low, the operand outputs hold steady. Input bytes are held off so that no byte is lost.
- R9: A zero descriptor before a nonzero one, or a nonzero descriptor with access code 0 or 3, sets `fmt_err` until reset. Such a record produces no operands and no `rec_done`, and the next byte starts a new record.
- R10: With the speculation word disabled, a record starts at its opcode byte and `rec_spec_flag` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block takes the byte this cycle |
| op_valid | output | 1 | Operand on the outputs |
| op_ready | input | 1 | Consumer takes the operand |
| op_size | output | 4 | Operand size in bytes (1, 2, 4, 8) |
| op_is_write | output | 1 | 1 for written operand, 0 for read |
| op_is_mem | output | 1 | 1 for memory address, 0 for register |
| op_value | output | 32 | Address or register number |
| op_index | output | 3 | Descriptor position of the operand |
| rec_spec_flag | output | 32 | Speculation word of the record |
| rec_opcode | output | 8 | Opcode of the record |
| rec_done | output | 1 | One-cycle end-of-record pulse |
| fmt_err | output | 1 | Sticky descriptor format error |

## Verification
The bench builds instance u0 with the speculation word enabled and the default six descriptors and 4-byte words. This reaches every size and access code, six-operand and zero-operand records, register 0 and the most negative word, and all three kinds of malformed descriptor. Random input gaps and heavy output backpressure on u0 exercise the stall path and the exact cycle of the done pulse. A second instance, u1, drops the speculation word so that records starting at the opcode byte are covered.

// File: rtl/trp_pkg.sv
package trp_pkg;

    typedef enum logic [2:0] {
        ST_FLAG  = 3'd0,
        ST_OPC   = 3'd1,
        ST_DESC  = 3'd2,
        ST_WORD  = 3'd3,
        ST_DRAIN = 3'd4
    } trp_state_e;

    localparam int unsigned NIB_W     = 4;
    localparam int unsigned SIZE_CODE = 2;
    localparam logic [1:0]  ACC_READ  = 2'd1;
    localparam logic [1:0]  ACC_WRITE = 2'd2;

endpackage

// File: rtl/trp_desc_decode.sv
module trp_desc_decode #(
    parameter int unsigned NDESC = 6,
    localparam int unsigned DESC_BITS = NDESC * 4,
    localparam int unsigned CW = $clog2(NDESC + 1)
) (
    input  logic [DESC_BITS-1:0] desc,
    output logic [CW-1:0]        used_cnt,
    output logic                 bad
);
    import trp_pkg::*;

    logic [NDESC-1:0] nz;
    logic [NDESC-1:0] acc_bad;
    logic [NDESC-1:0] gap_bad;

    for (genvar i = 0; i < NDESC; i++) begin : g_nib
        logic [3:0] nib;
        assign nib        = desc[DESC_BITS-1-4*i -: 4];
        assign nz[i]      = |nib;
        assign acc_bad[i] = nz[i] && (nib[1:0] != ACC_READ) && (nib[1:0] != ACC_WRITE);
        if (i == 0) begin : g_first
            assign gap_bad[i] = 1'b0;
        end else begin : g_rest
            assign gap_bad[i] = nz[i] && !nz[i-1];
        end
    end

    always_comb begin
        used_cnt = '0;
        for (int i = 0; i < NDESC; i++) begin
            used_cnt = used_cnt + CW'(nz[i]);
        end
        bad = |acc_bad || |gap_bad;
    end

endmodule

// File: rtl/trp_word_map.sv
module trp_word_map #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] word,
    output logic         is_mem,
    output logic [W-1:0] value
);
    always_comb begin
        is_mem = !word[W-1] && (|word);
        value  = is_mem ? word : (~word + W'(1));
    end
endmodule

// File: rtl/trp_out_slot.sv
module trp_out_slot #(
    parameter int unsigned W  = 32,
    parameter int unsigned IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [1:0]    ld_size_code,
    input  logic          ld_write,
    input  logic          ld_mem,
    input  logic [W-1:0]  ld_value,
    input  logic [IW-1:0] ld_idx,
    input  logic          op_ready,
    output logic          op_valid,
    output logic [3:0]    op_size,
    output logic          op_is_write,
    output logic          op_is_mem,
    output logic [W-1:0]  op_value,
    output logic [IW-1:0] op_index,
    output logic          free,
    output logic          fire
);
    typedef struct packed {
        logic          vld;
        logic [3:0]    size;
        logic          wr;
        logic          mem;
        logic [W-1:0]  val;
        logic [IW-1:0] idx;
    } slot_t;

    slot_t s_d, s_q;

    assign fire = s_q.vld && op_ready;
    assign free = !s_q.vld || op_ready;

    always_comb begin
        s_d = s_q;
        if (fire) s_d.vld = 1'b0;
        if (load) begin
            s_d.vld  = 1'b1;
            s_d.size = 4'd1 << ld_size_code;
            s_d.wr   = ld_write;
            s_d.mem  = ld_mem;
            s_d.val  = ld_value;
            s_d.idx  = ld_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign op_valid    = s_q.vld;
    assign op_size     = s_q.size;
    assign op_is_write = s_q.wr;
    assign op_is_mem   = s_q.mem;
    assign op_value    = s_q.val;
    assign op_index    = s_q.idx;

    // R8
    op_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_ready |=> op_valid && $stable(op_value) && $stable(op_size)
                                  && $stable(op_index) && $stable(op_is_mem) && $stable(op_is_write));
    // R4
    size_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $countones(op_size) == 1);
    // R6
    mem_positive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_is_mem |-> !op_value[W-1] && (op_value != '0));

endmodule

// File: rtl/trace_rec_parser.sv
module trace_rec_parser #(
    parameter bit          SPEC_FIELD = 1'b1,
    parameter int unsigned NDESC      = 6,
    parameter int unsigned WORD_BYTES = 4,
    localparam int unsigned WORD_W    = WORD_BYTES * 8,
    localparam int unsigned IDXW      = $clog2(NDESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              op_valid,
    input  logic              op_ready,
    output logic [3:0]        op_size,
    output logic              op_is_write,
    output logic              op_is_mem,
    output logic [WORD_W-1:0] op_value,
    output logic [IDXW-1:0]   op_index,
    output logic [WORD_W-1:0] rec_spec_flag,
    output logic [7:0]        rec_opcode,
    output logic              rec_done,
    output logic              fmt_err
);
    import trp_pkg::*;

    localparam int unsigned DESC_BITS  = NDESC * 4;
    localparam int unsigned DESC_BYTES = DESC_BITS / 8;
    localparam int unsigned CW         = $clog2(NDESC + 1);
    localparam int unsigned MAXB       = (WORD_BYTES > DESC_BYTES) ? WORD_BYTES : DESC_BYTES;
    localparam int unsigned CNTW       = $clog2(MAXB + 1);
    localparam logic [CNTW-1:0] WLAST  = CNTW'(WORD_BYTES - 1);
    localparam logic [CNTW-1:0] DLAST  = CNTW'(DESC_BYTES - 1);
    localparam trp_state_e START_ST    = SPEC_FIELD ? ST_FLAG : ST_OPC;

    typedef struct packed {
        trp_state_e           st;
        logic [CNTW-1:0]      cnt;
        logic [WORD_W-1:0]    flag;
        logic [7:0]           opc;
        logic [DESC_BITS-1:0] desc;
        logic [WORD_W-9:0]    wacc;
        logic [IDXW-1:0]      idx;
        logic [CW-1:0]        nops;
        logic                 done;
        logic                 err;
    } regs_t;

    regs_t r_d, r_q;

    logic                 slot_free, slot_fire, load;
    logic [DESC_BITS-1:0] desc_shift;
    logic [WORD_W-1:0]    word_full;
    logic [CW-1:0]        used_cnt;
    logic                 desc_bad;
    logic                 w_is_mem;
    logic [WORD_W-1:0]    w_value;
    logic [3:0]           cur_nib;
    logic                 acc;
    logic                 last_op;

    assign desc_shift = {r_q.desc[DESC_BITS-9:0], in_data};
    assign word_full  = {r_q.wacc, in_data};
    assign cur_nib    = 4'(r_q.desc >> (DESC_BITS - 4 - 4 * int'(r_q.idx)));
    assign last_op    = (CW'(r_q.idx) + CW'(1)) == r_q.nops;

    trp_desc_decode #(.NDESC(NDESC)) u_dec (
        .desc     (desc_shift),
        .used_cnt (used_cnt),
        .bad      (desc_bad)
    );

    trp_word_map #(.W(WORD_W)) u_map (
        .word   (word_full),
        .is_mem (w_is_mem),
        .value  (w_value)
    );

    always_comb begin
        case (r_q.st)
            ST_FLAG, ST_OPC, ST_DESC: in_ready = 1'b1;
            ST_WORD:                  in_ready = (r_q.cnt != WLAST) || slot_free;
            default:                  in_ready = 1'b0;
        endcase
    end

    assign acc = in_valid && in_ready;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        load     = 1'b0;
        case (r_q.st)
            ST_FLAG: if (acc) begin
                r_d.flag = {r_q.flag[WORD_W-9:0], in_data};
                r_d.cnt  = r_q.cnt + CNTW'(1);
                if (r_q.cnt == WLAST) begin
                    r_d.cnt = '0;
                    r_d.st  = ST_OPC;
                end
            end
            ST_OPC: if (acc) begin
                r_d.opc = in_data;
                r_d.cnt = '0;
                r_d.st  = ST_DESC;
            end
            ST_DESC: if (acc) begin
                r_d.desc = desc_shift;
                r_d.cnt  = r_q.cnt + CNTW'(1);
                if (r_q.cnt == DLAST) begin
                    r_d.cnt = '0;
                    r_d.idx = '0;
                    if (desc_bad) begin
                        r_d.err = 1'b1;
                        r_d.st  = START_ST;
                    end else if (used_cnt == '0) begin
                        r_d.done = 1'b1;
                        r_d.st   = START_ST;
                    end else begin
                        r_d.nops = used_cnt;
                        r_d.st   = ST_WORD;
                    end
                end
            end
            ST_WORD: if (acc) begin
                r_d.wacc = word_full[WORD_W-9:0];
                r_d.cnt  = r_q.cnt + CNTW'(1);
                if (r_q.cnt == WLAST) begin
                    r_d.cnt = '0;
                    load    = 1'b1;
                    r_d.idx = r_q.idx + IDXW'(1);
                    if (last_op) r_d.st = ST_DRAIN;
                end
            end
            ST_DRAIN: if (slot_fire) begin
                r_d.done = 1'b1;
                r_d.st   = START_ST;
            end
            default: r_d.st = START_ST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= START_ST;
        end else begin
            r_q <= r_d;
        end
    end

    trp_out_slot #(.W(WORD_W), .IW(IDXW)) u_slot (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .ld_size_code (cur_nib[3:2]),
        .ld_write     (cur_nib[1:0] == ACC_WRITE),
        .ld_mem       (w_is_mem),
        .ld_value     (w_value),
        .ld_idx       (r_q.idx),
        .op_ready     (op_ready),
        .op_valid     (op_valid),
        .op_size      (op_size),
        .op_is_write  (op_is_write),
        .op_is_mem    (op_is_mem),
        .op_value     (op_value),
        .op_index     (op_index),
        .free         (slot_free),
        .fire         (slot_fire)
    );

    assign rec_spec_flag = SPEC_FIELD ? r_q.flag : '0;
    assign rec_opcode    = r_q.opc;
    assign rec_done      = r_q.done;
    assign fmt_err       = r_q.err;

    // R8
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!op_valid || op_ready));
    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |-> !op_valid);
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |=> !rec_done);
    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |=> fmt_err);

endmodule

// File: tb/sim_trace_rec_parser.sv
module sim_trace_rec_parser;

    typedef struct {
        logic [3:0]  sz;
        logic        wr;
        logic        mem;
        logic [31:0] val;
        int          idx;
        bit          last;
    } exp_op_t;

    typedef struct {
        logic [31:0] flag;
        logic [7:0]  opc;
    } exp_rec_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        op_ready = 1'b1;
    logic        in_ready, op_valid, op_is_write, op_is_mem, rec_done, fmt_err;
    logic [3:0]  op_size;
    logic [31:0] op_value, rec_spec_flag;
    logic [2:0]  op_index;
    logic [7:0]  rec_opcode;

    trace_rec_parser #(.SPEC_FIELD(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .op_valid(op_valid), .op_ready(op_ready), .op_size(op_size), .op_is_write(op_is_write),
        .op_is_mem(op_is_mem), .op_value(op_value), .op_index(op_index),
        .rec_spec_flag(rec_spec_flag), .rec_opcode(rec_opcode), .rec_done(rec_done), .fmt_err(fmt_err)
    );

    logic        u1_in_valid = 1'b0;
    logic [7:0]  u1_in_data = 8'h00;
    logic        u1_op_ready = 1'b1;
    logic        u1_in_ready, u1_op_valid, u1_op_is_write, u1_op_is_mem, u1_rec_done, u1_fmt_err;
    logic [3:0]  u1_op_size;
    logic [31:0] u1_op_value, u1_rec_spec_flag;
    logic [2:0]  u1_op_index;
    logic [7:0]  u1_rec_opcode;

    trace_rec_parser #(.SPEC_FIELD(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(u1_in_valid), .in_data(u1_in_data), .in_ready(u1_in_ready),
        .op_valid(u1_op_valid), .op_ready(u1_op_ready), .op_size(u1_op_size), .op_is_write(u1_op_is_write),
        .op_is_mem(u1_op_is_mem), .op_value(u1_op_value), .op_index(u1_op_index),
        .rec_spec_flag(u1_rec_spec_flag), .rec_opcode(u1_rec_opcode), .rec_done(u1_rec_done), .fmt_err(u1_fmt_err)
    );

    int compared = 0;
    int mismatched = 0;

    logic [7:0] byte_q [$];
    int         tag_q [$];
    exp_op_t    exp_op_q [$];
    exp_rec_t   exp_rec_q [$];

    bit run = 0;
    int gap_mode = 0;
    int rdy_mode = 0;
    bit in_acc_seen = 0;
    bit done_due = 0;
    bit err_pend = 0;
    bit exp_err = 0;
    bit stall_prev = 0;
    logic [31:0] sv_val;
    logic [3:0]  sv_sz;
    logic [2:0]  sv_idx;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        compared++;
        if (act !== expv) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, expv, $time);
        end
    endtask

    task automatic push_word(input logic [31:0] w, input int tag);
        for (int b = 3; b >= 0; b--) begin
            byte_q.push_back(w[8*b +: 8]);
            tag_q.push_back((b == 0) ? tag : 0);
        end
    endtask

    task automatic add_rec(input logic [31:0] flag, input logic [7:0] opc, input logic [23:0] descw,
                           input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2,
                           input logic [31:0] w3, input logic [31:0] w4, input logic [31:0] w5);
        logic [31:0] ws [6];
        int n;
        bit err, seen_zero;
        ws[0] = w0; ws[1] = w1; ws[2] = w2; ws[3] = w3; ws[4] = w4; ws[5] = w5;
        n = 0; err = 0; seen_zero = 0;
        for (int k = 0; k < 6; k++) begin
            logic [3:0] nib;
            nib = descw[23 - 4*k -: 4];
            if (nib != 0) begin
                if (seen_zero) err = 1;
                if (nib[1:0] == 2'd0 || nib[1:0] == 2'd3) err = 1;
                n++;
            end else begin
                seen_zero = 1;
            end
        end
        push_word(flag, 0);
        byte_q.push_back(opc); tag_q.push_back(0);
        for (int b = 2; b >= 0; b--) begin
            byte_q.push_back(descw[8*b +: 8]);
            tag_q.push_back((b != 0) ? 0 : (err ? 2 : (n == 0 ? 1 : 0)));
        end
        if (!err) begin
            exp_rec_t r;
            r.flag = flag; r.opc = opc;
            exp_rec_q.push_back(r);
            for (int k = 0; k < n; k++) begin
                exp_op_t e;
                logic [3:0] nib;
                nib   = descw[23 - 4*k -: 4];
                e.sz  = 4'd1 << nib[3:2];
                e.wr  = (nib[1:0] == 2'd2);
                e.mem = ($signed(ws[k]) > 0);
                e.val = e.mem ? ws[k] : (32'd0 - ws[k]);
                e.idx = k;
                e.last = (k == n - 1);
                exp_op_q.push_back(e);
                push_word(ws[k], 0);
            end
        end
    endtask

    // driver: after each edge
    always begin
        @(posedge clk);
        #2;
        if (run) begin
            if (in_acc_seen) begin
                void'(byte_q.pop_front());
                in_valid = 1'b0;
            end
            in_acc_seen = 0;
            if (!in_valid && byte_q.size() > 0 && (gap_mode == 0 || $urandom_range(3) != 0))
                in_valid = 1'b1;
            if (in_valid) in_data = byte_q[0];
            case (rdy_mode)
                0:       op_ready = 1'b1;
                1:       op_ready = ($urandom_range(1) == 1);
                default: op_ready = ($urandom_range(3) == 0);
            endcase
        end
    end

    // reference comparison at every falling edge
    always @(negedge clk) begin
        if (run) begin
            bit new_due;
            if (err_pend) begin exp_err = 1; err_pend = 0; end
            chk("R9 fmt_err", 32'(fmt_err), 32'(exp_err));
            chk("R7 rec_done timing", 32'(rec_done), 32'(done_due));
            new_due = 0;
            if (rec_done) begin
                if (exp_rec_q.size() > 0) begin
                    exp_rec_t r;
                    r = exp_rec_q.pop_front();
                    chk("R2 spec flag", rec_spec_flag, r.flag);
                    chk("R3 opcode", 32'(rec_opcode), 32'(r.opc));
                end else chk("R7 unexpected done", 32'd1, 32'd0);
            end
            if (stall_prev) begin
                chk("R8 valid held", 32'(op_valid), 32'd1);
                chk("R8 value held", op_value, sv_val);
                chk("R8 size held", 32'(op_size), 32'(sv_sz));
                chk("R8 index held", 32'(op_index), 32'(sv_idx));
            end
            if (op_valid && op_ready) begin
                if (exp_op_q.size() > 0) begin
                    exp_op_t e;
                    e = exp_op_q.pop_front();
                    chk("R4 size", 32'(op_size), 32'(e.sz));
                    chk("R4 direction", 32'(op_is_write), 32'(e.wr));
                    chk("R6 reg/mem", 32'(op_is_mem), 32'(e.mem));
                    chk("R6 value", op_value, e.val);
                    chk("R5 index", 32'(op_index), 32'(e.idx));
                    if (e.last) new_due = 1;
                end else chk("R5 extra operand", 32'd1, 32'd0);
            end
            stall_prev = op_valid && !op_ready;
            sv_val = op_value; sv_sz = op_size; sv_idx = op_index;
            if (in_valid && in_ready) begin
                int t;
                in_acc_seen = 1;
                t = tag_q.pop_front();
                if (t == 1) new_due = 1;
                if (t == 2) err_pend = 1;
            end
            done_due = new_due;
        end
    end

    logic [31:0] u1_vals [$];
    logic        u1_mems [$];
    int          u1_done_cnt = 0;
    logic [7:0]  u1_opc_seen = 8'h00;
    logic [31:0] u1_flag_seen = 32'hFFFF_FFFF;

    always @(negedge clk) begin
        if (rst_n) begin
            if (u1_op_valid) begin
                u1_vals.push_back(u1_op_value);
                u1_mems.push_back(u1_op_is_mem);
            end
            if (u1_rec_done) begin
                u1_done_cnt++;
                u1_opc_seen  = u1_rec_opcode;
                u1_flag_seen = u1_rec_spec_flag;
            end
        end
    end

    task automatic u1_send(input logic [7:0] b);
        @(posedge clk); #2;
        u1_in_valid = 1'b1;
        u1_in_data  = b;
        @(negedge clk);
        while (!u1_in_ready) @(negedge clk);
        @(posedge clk); #2;
        u1_in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        wait (byte_q.size() == 0 && exp_op_q.size() == 0 && !in_valid);
        repeat (8) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 op_valid in reset", 32'(op_valid), 32'd0);
        chk("R1 rec_done in reset", 32'(rec_done), 32'd0);
        chk("R1 fmt_err in reset", 32'(fmt_err), 32'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 in_ready after reset", 32'(in_ready), 32'd1);
        chk("R1 op_valid after reset", 32'(op_valid), 32'd0);
        run = 1;

        // streaming, no stalls
        add_rec(32'h0000_0000, 8'h11, 24'h9A0000, 32'hFFFF_FFFB, 32'h0000_0400, 0, 0, 0, 0);
        add_rec(32'h8000_0000, 8'h22, 24'h000000, 0, 0, 0, 0, 0, 0);
        add_rec(32'h0000_0000, 8'h33, 24'h159ED6, 32'h0, 32'h8000_0000, 32'h1,
                32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h1234_5678);
        wait_idle();

        // gaps and backpressure
        gap_mode = 1;
        for (int m = 1; m <= 2; m++) begin
            rdy_mode = m;
            for (int i = 0; i < 6; i++) begin
                logic [31:0] base;
                base = 32'(i * 32'h0101_0103 + m);
                case (i % 3)
                    0: add_rec(base, 8'(i + 8'h40), 24'h5E9D16, base, -base, base + 7, 32'h0,
                               32'h8000_0001, base ^ 32'hF0F0_0F0F);
                    1: add_rec(32'h8000_0000, 8'(i + 8'h50), 24'h000000, 0, 0, 0, 0, 0, 0);
                    default: add_rec(32'h0, 8'(i + 8'h60), 24'hA00000, 32'(-i), 0, 0, 0, 0, 0);
                endcase
            end
            wait_idle();
        end

        // malformed records, then a good one to show resync
        rdy_mode = 0;
        add_rec(32'h0000_0001, 8'h71, 24'h090000, 0, 0, 0, 0, 0, 0);
        add_rec(32'h0000_0002, 8'h72, 24'h700000, 0, 0, 0, 0, 0, 0);
        add_rec(32'h0000_0003, 8'h73, 24'h980000, 0, 0, 0, 0, 0, 0);
        add_rec(32'h8000_0000, 8'h74, 24'h9A0000, 32'h0000_2000, 32'hFFFF_FFFE, 0, 0, 0, 0);
        wait_idle();
        chk("R5 all operands seen", 32'(exp_op_q.size()), 32'd0);
        chk("R7 all records ended", 32'(exp_rec_q.size()), 32'd0);
        run = 0;

        // variant without the speculation word
        u1_send(8'h42);
        u1_send(8'h9A); u1_send(8'h00); u1_send(8'h00);
        u1_send(8'hFF); u1_send(8'hFF); u1_send(8'hFF); u1_send(8'hFD);
        u1_send(8'h00); u1_send(8'h00); u1_send(8'h10); u1_send(8'h00);
        repeat (6) @(posedge clk);
        chk("R10 operand count", 32'(u1_vals.size()), 32'd2);
        if (u1_vals.size() == 2) begin
            chk("R10 first value", u1_vals[0], 32'd3);
            chk("R10 first is register", 32'(u1_mems[0]), 32'd0);
            chk("R10 second value", u1_vals[1], 32'h0000_1000);
            chk("R10 second is memory", 32'(u1_mems[1]), 32'd1);
        end
        chk("R10 done count", 32'(u1_done_cnt), 32'd1);
        chk("R10 opcode", 32'(u1_opc_seen), 32'h42);
        chk("R10 flag reads zero", u1_flag_seen, 32'h0);
        chk("R10 no format error", 32'(u1_fmt_err), 32'd0);

        finish_run();
    end

endmodule